// File: doc/BRIEF.md
# Sort-then-route self-routing cell switch

This block moves one slot's worth of fixed-size cells across an eight-port fabric without any central scheduler. Every input offers a valid flag, a three-bit destination port and a payload word. When the slot strobe is sampled high, the block captures all eight inputs. A compare-exchange sorting network then arranges the active cells so that their destinations rise strictly from port position 0 upward, and idle cells collect at the top positions. A three-stage shuffle-exchange routing network then steers each cell. Every 2x2 switch in that network looks only at one bit of the cell's own destination.

The sorting stage makes the request list compact and monotone. Because of that, no two cells ever compete for the same internal link in the routing stage, even though the routing network has only N·log2N/2 switches. The surrounding logic must deliver destinations that do not collide within a slot. Contention between cells bound for the same output, queueing and multicast are handled outside the block. The results appear one clock after the strobe edge and stay on the outputs until the next slot completes.

Top module: `sortroute_fabric`

## Requirements
- R1: After reset, every `out_vld` bit is 0 and `out_rdy` is 0.
- R2: When `slot_go` is high at a rising edge, the inputs are captured at that edge, and the routed results plus a one-cycle `out_rdy` pulse appear after the following rising edge.
- R3: The sorter orders cells by the key {idle, destination}, with idle = 1 for an inactive input. Its output is ascending from position 0 to 7, so every active cell lies below every idle cell.
- R4: The payload of each active input whose destination is d (0..7) is delivered on output port d, in bits [16d+15:16d] of `out_data`.
- R5: For a set of active destinations with no duplicates, no routing switch ever receives two active cells that want the same switch output.
- R6: `out_vld[p]` is 1 exactly when some active input in the slot addressed port p. The number of valid outputs equals the number of active inputs.
- R7: Between slots, the outputs hold their values, and input changes without `slot_go` have no effect on them.
- R8: With sources 0..7 carrying destinations 6, 4, idle, 3, 7, 2, idle, 1, ports 1, 2, 3, 4, 6 and 7 are valid and carry the payloads of sources 7, 5, 3, 1, 0 and 4, while ports 0 and 5 are idle.
- R9: A slot with no active input produces no valid output, and a slot with all eight inputs active fills all eight outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_go | input | 1 | Slot strobe; captures all inputs |
| in_vld | input | 8 | Per-input active flag |
| in_dst | input | 24 | Destination port per input, 3 bits each, input i at [3i+2:3i] |
| in_data | input | 128 | Payload per input, 16 bits each, input i at [16i+15:16i] |
| out_vld | output | 8 | Per-output valid flag |
| out_data | output | 128 | Payload per output, port p at [16p+15:16p] |
| out_rdy | output | 1 | One-cycle pulse when new results appear |

## Verification
The sweep crosses 32 conflict-free destination permutations of the form (a·i+b) mod 8, with a odd, against all 256 idle masks. Together these cover every amount of activity and every way gaps can sit among the sorted cells. This is what separates a correct compaction from one that only works for full or contiguous loads. The all-idle and all-active masks isolate the empty and full corners. The worked six-cell example pins down the exact source-to-port mapping. A separate hold test changes inputs without a strobe, which exposes any leak from the inputs to the outputs outside a slot.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int PORTS    = 8;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = $clog2(PORTS);
    localparam int LVLS     = ADDR_W;
    localparam int SORT_STG = LVLS * (LVLS + 1) / 2;
    localparam int KEY_W    = ADDR_W + 1;

    typedef struct packed {
        logic              idle;
        logic [ADDR_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } cell_t;

    localparam cell_t EMPTY_CELL = '{idle: 1'b1, dst: '0, data: '0};

    typedef struct packed {
        logic                   pend;
        logic                   rdy;
        cell_t [PORTS-1:0]      cin;
        cell_t [PORTS-1:0]      cout;
    } fab_state_t;

    // inverse perfect shuffle on ADDR_W bits
    function automatic int unsigned rotr(input int unsigned q);
        return ((q >> 1) | ((q & 1) << (ADDR_W - 1))) & (PORTS - 1);
    endfunction
endpackage

// File: rtl/sr_cmpx.sv
module sr_cmpx
    import sr_pkg::*;
#(
    parameter bit DESC = 1'b0
) (
    input  cell_t a_i,
    input  cell_t b_i,
    output cell_t lo_o,
    output cell_t hi_o
);
    logic [KEY_W-1:0] ka, kb;
    logic             swap;

    always_comb begin
        ka   = {a_i.idle, a_i.dst};
        kb   = {b_i.idle, b_i.dst};
        swap = DESC ? (ka < kb) : (ka > kb);
        lo_o = swap ? b_i : a_i;
        hi_o = swap ? a_i : b_i;
    end
endmodule

// File: rtl/sr_sorter.sv
module sr_sorter
    import sr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cell_t cells_i [PORTS],
    output cell_t cells_o [PORTS]
);
    cell_t st [SORT_STG+1][PORTS];

    for (genvar p = 0; p < PORTS; p++) begin : g_in
        assign st[0][p] = cells_i[p];
        assign cells_o[p] = st[SORT_STG][p];
    end

    // merge level kk builds bitonic runs of length 2^kk; sub-step jj halves the span
    for (genvar kk = 1; kk <= LVLS; kk++) begin : g_lvl
        for (genvar jb = 0; jb < kk; jb++) begin : g_sub
            localparam int JJ  = kk - 1 - jb;
            localparam int STG = kk * (kk - 1) / 2 + jb;
            for (genvar i = 0; i < PORTS; i++) begin : g_el
                if (((i >> JJ) & 1) == 0) begin : g_pair
                    sr_cmpx #(.DESC(((i >> kk) & 1) == 1)) cmpx_i (
                        .a_i  (st[STG][i]),
                        .b_i  (st[STG][i + (1 << JJ)]),
                        .lo_o (st[STG+1][i]),
                        .hi_o (st[STG+1][i + (1 << JJ)])
                    );
                end
            end
        end
    end

    for (genvar p = 0; p < PORTS - 1; p++) begin : g_chk
        // R3
        sort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            {cells_o[p].idle, cells_o[p].dst} <= {cells_o[p+1].idle, cells_o[p+1].dst});
    end
endmodule

// File: rtl/sr_bswitch.sv
module sr_bswitch
    import sr_pkg::*;
#(
    parameter int BIT = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  cell_t a_i,
    input  cell_t b_i,
    output cell_t up_o,
    output cell_t dn_o
);
    logic a_dn, b_dn;

    always_comb begin
        a_dn = a_i.dst[BIT];
        b_dn = b_i.dst[BIT];
        up_o = EMPTY_CELL;
        dn_o = EMPTY_CELL;
        if (!b_i.idle) begin
            if (b_dn) dn_o = b_i;
            else      up_o = b_i;
        end
        if (!a_i.idle) begin
            if (a_dn) dn_o = a_i;
            else      up_o = a_i;
        end
    end

    // R5
    no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!a_i.idle && !b_i.idle && (a_dn == b_dn)));
endmodule

// File: rtl/sr_banyan.sv
module sr_banyan
    import sr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cell_t cells_i [PORTS],
    output cell_t cells_o [PORTS]
);
    cell_t bn [LVLS+1][PORTS];

    for (genvar p = 0; p < PORTS; p++) begin : g_io
        assign bn[0][p]   = cells_i[p];
        assign cells_o[p] = bn[LVLS][p];
    end

    // each stage: shuffle, then exchange on one destination bit, most significant first
    for (genvar s = 0; s < LVLS; s++) begin : g_stg
        for (genvar k = 0; k < PORTS / 2; k++) begin : g_sw
            sr_bswitch #(.BIT(LVLS - 1 - s)) sw_i (
                .clk  (clk),
                .rst_n(rst_n),
                .a_i  (bn[s][rotr(2 * k)]),
                .b_i  (bn[s][rotr(2 * k + 1)]),
                .up_o (bn[s+1][2 * k]),
                .dn_o (bn[s+1][2 * k + 1])
            );
        end
    end
endmodule

// File: rtl/sortroute_fabric.sv
module sortroute_fabric
    import sr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slot_go,
    input  logic [PORTS-1:0]          in_vld,
    input  logic [PORTS*ADDR_W-1:0]   in_dst,
    input  logic [PORTS*DATA_W-1:0]   in_data,
    output logic [PORTS-1:0]          out_vld,
    output logic [PORTS*DATA_W-1:0]   out_data,
    output logic                      out_rdy
);
    fab_state_t st_d, st_q;
    cell_t      sort_in  [PORTS];
    cell_t      sorted   [PORTS];
    cell_t      routed   [PORTS];
    logic [PORTS-1:0] cin_act;

    for (genvar p = 0; p < PORTS; p++) begin : g_map
        assign sort_in[p] = st_q.cin[p];
        assign cin_act[p] = ~st_q.cin[p].idle;
        assign out_vld[p] = ~st_q.cout[p].idle;
        assign out_data[p*DATA_W +: DATA_W] = st_q.cout[p].data;
    end
    assign out_rdy = st_q.rdy;

    sr_sorter sorter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cells_i(sort_in),
        .cells_o(sorted)
    );

    sr_banyan banyan_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cells_i(sorted),
        .cells_o(routed)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b0;
        if (st_q.pend) begin
            for (int p = 0; p < PORTS; p++) st_d.cout[p] = routed[p];
            st_d.rdy = 1'b1;
        end
        st_d.pend = slot_go;
        if (slot_go) begin
            for (int i = 0; i < PORTS; i++) begin
                st_d.cin[i].idle = ~in_vld[i];
                st_d.cin[i].dst  = in_dst[i*ADDR_W +: ADDR_W];
                st_d.cin[i].data = in_data[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= 1'b0;
            st_q.rdy  <= 1'b0;
            for (int p = 0; p < PORTS; p++) begin
                st_q.cin[p]  <= EMPTY_CELL;
                st_q.cout[p] <= EMPTY_CELL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go |=> ##1 out_rdy);
    // R6
    count_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> $countones(out_vld) == $past($countones(cin_act)));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |=> $stable(out_vld) && $stable(out_data));
    for (genvar p = 0; p < PORTS; p++) begin : g_dchk
        // R4
        route_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.cout[p].idle |-> st_q.cout[p].dst == ADDR_W'(p));
    end
endmodule

// File: tb/sortroute_fabric_tb.sv
module sortroute_fabric_tb_top;
    localparam int  P   = 8;
    localparam int  A   = 3;
    localparam int  D   = 16;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slot_go = 1'b0;
    logic [P-1:0]     in_vld = '0;
    logic [P*A-1:0]   in_dst = '0;
    logic [P*D-1:0]   in_data = '0;
    logic [P-1:0]     out_vld;
    logic [P*D-1:0]   out_data;
    logic             out_rdy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sortroute_fabric dut_i (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go),
        .in_vld(in_vld), .in_dst(in_dst), .in_data(in_data),
        .out_vld(out_vld), .out_data(out_data), .out_rdy(out_rdy)
    );

    logic [P-1:0]   exp_vld;
    logic [P*D-1:0] exp_data;

    task automatic compute_expect();
        exp_vld  = '0;
        exp_data = '0;
        for (int i = 0; i < P; i++) begin
            if (in_vld[i]) begin
                exp_vld[in_dst[i*A +: A]] = 1'b1;
                exp_data[in_dst[i*A +: A]*D +: D] = in_data[i*D +: D];
            end
        end
    endtask

    task automatic check_out(input string tag);
        checks++;
        if (out_vld !== exp_vld || out_data !== exp_data) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s: vld=%b data=%h expected vld=%b data=%h",
                         tag, out_vld, out_data, exp_vld, exp_data);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // drive at a falling edge, strobe one cycle, sample one cycle after results appear
    task automatic run_slot(input string tag);
        slot_go = 1'b1;
        compute_expect();
        @(negedge clk);
        slot_go = 1'b0;
        @(negedge clk);
        check_bit({tag, " R2 rdy"}, out_rdy, 1'b1);
        check_out(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 reset vld", |out_vld, 1'b0);
        check_bit("R1 reset rdy", out_rdy, 1'b0);

        // R8 worked example
        in_vld = 8'b1011_1011;
        begin
            int dl [P] = '{6, 4, 0, 3, 7, 2, 0, 1};
            for (int i = 0; i < P; i++) begin
                in_dst[i*A +: A]  = A'(dl[i]);
                in_data[i*D +: D] = 16'hA0 + 16'(i);
            end
        end
        run_slot("R8 example");
        check_bit("R8 port5 idle", out_vld[5], 1'b0);
        check_bit("R8 port1 from src7", out_data[1*D +: D] == 16'hA7, 1'b1);

        // R7: change inputs without a strobe
        in_vld  = 8'hFF;
        in_data = {P{16'h5555}};
        @(negedge clk);
        check_bit("R7 rdy low", out_rdy, 1'b0);
        @(negedge clk);
        check_bit("R7 data hold", out_data[1*D +: D] == 16'hA7, 1'b1);
        check_bit("R7 vld hold", out_vld == 8'b1101_1110, 1'b1);

        // R4 R6 R9 sweep: permutations (a*i+b) mod 8 against every idle mask
        for (int a = 1; a < 8; a += 2) begin
            for (int b = 0; b < 8; b++) begin
                for (int m = 0; m < 256; m++) begin
                    in_vld = P'(m);
                    for (int i = 0; i < P; i++) begin
                        in_dst[i*A +: A]  = A'((a * i + b) % 8);
                        in_data[i*D +: D] = 16'((a << 12) ^ (b << 9) ^ (m << 3) ^ i);
                    end
                    if (m == 0)        run_slot("R9 all idle");
                    else if (m == 255) run_slot("R9 all active");
                    else               run_slot("R4 R6 sweep");
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule